// File: doc/BRIEF.md
# Indirect Codec Register Access Bridge

This block sits on the host bus and gives software access to a small bank of 8-bit codec control registers through only two 32-bit words. The command word carries a register index, a data byte and a request bit. Setting the request bit starts a write, and the same bit then reads back as a busy flag until the write has landed. The status word returns the byte of the register selected by the command word's index, and a summary interrupt bit.

A read needs no request. The host stores a new index with the request bit clear, waits out the fixed settle time, and then takes the byte from the status word. Two slots in the bank are reserved test registers that ignore writes and read as zero. Indices beyond the bank behave the same way. One register holds two completion flags. A pulse on a hardware input sets each flag, and the host clears it by writing zero. If a set and a clear land in the same cycle, the set wins.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset the command word reads 0x00000000 and the busy bit is clear.
- R2: The command word is at byte offset 0x0, with request/busy at bit 16, the register index at bits 14:8 and the data byte at bits 7:0. The status word is at 0x4, with the selected byte at bits 7:0 and the interrupt at bit 8. All other bits read 0, every other offset reads 0, and host writes to 0x4 change nothing.
- R3: When a command-word write with bit 16 set is accepted, bit 16 reads 1 for exactly 4 cycles. The addressed register takes the data byte at the clock edge where bit 16 returns to 0.
- R4: Any command-word write that arrives while busy is ignored, and the pending write completes with its original index and data.
- R5: A command-word write with bit 16 clear, accepted while idle, updates only the index and data fields and modifies no register.
- R6: Status bits 7:0 show the byte selected by the index. A change of index first shows there 6 cycles after the edge that stored it: the old value is still visible after 5 cycles.
- R7: Indices 20 and 21, and all indices from 28 to 127, ignore writes and read 0x00.
- R8: Register 9 holds two flags. Bit 3 is set by a one-cycle pulse on ramp_up_done and bit 2 by a pulse on ramp_down_done. A host write stores its byte in the register. When a pulse and a host write hit the same edge, the pulsed bit ends up 1.
- R9: Status bit 8 is 1 exactly when register 9 is non-zero. It follows the register with no settle delay.
- R10: Registers 0 to 27 reset to 0c aa 78 00 00 ff 03 51 3f 00 00 04 04 04 04 04 04 0a 0a 00 00 00 c0 34 07 44 1f 00, in index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one word per cycle |
| host_addr | input | 4 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| ramp_up_done | input | 1 | Pulse that sets flag bit 3 of register 9 |
| ramp_down_done | input | 1 | Pulse that sets flag bit 2 of register 9 |

## Verification
The bench sweeps the whole index range by read, including the reserved and out-of-range indices. This separates a wrong reset table or a missing block on writes from a wrong read path. It also writes while idle, writes again while busy, and stores an index without the request bit. These three cases tell the busy window, the ignore rule and the request gating apart. A read that moves between two registers with different values fixes the exact settle cycle. Flag pulses are placed alone and then on the same edge as a host clear, which shows whether the set-over-clear priority holds.

// File: rtl/codec_bridge_pkg.sv
// Package: shared constants and the reset table of the codec register bank.
// Assumes registers are 8 bits wide and indexed from 0.
package codec_bridge_pkg;

    localparam int REG_COUNT    = 28;
    localparam int IDX_W        = 7;
    localparam int BYTE_W       = 8;
    localparam int FLAG_IDX     = 9;
    localparam int TEST_IDX_A   = 20;
    localparam int TEST_IDX_B   = 21;
    localparam int RAMP_UP_BIT  = 3;
    localparam int RAMP_DN_BIT  = 2;

    // Reset byte of each register index; unknown indices give zero.
    function automatic logic [7:0] reg_reset_value(input int idx);
        case (idx)
            0:  return 8'h0c;
            1:  return 8'haa;
            2:  return 8'h78;
            5:  return 8'hff;
            6:  return 8'h03;
            7:  return 8'h51;
            8:  return 8'h3f;
            11, 12, 13, 14, 15, 16: return 8'h04;
            17, 18: return 8'h0a;
            22: return 8'hc0;
            23: return 8'h34;
            24: return 8'h07;
            25: return 8'h44;
            26: return 8'h1f;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/codec_cmd_ctrl.sv
// Command word holder: keeps the index and data fields, runs the busy
// window of a write request and pulses commit on its last cycle.
// Assumes BUSY_CYCLES >= 1; writes that arrive while busy are dropped.
module codec_cmd_ctrl #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              req_bit,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output logic              commit,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Accept a command while idle and count down the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else if (cmd_wr && (cnt_q == '0)) begin
            cmd_addr <= addr_in;
            cmd_data <= data_in;
            cnt_q    <= req_bit ? CNT_W'(BUSY_CYCLES) : '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Busy while counting; the final counted cycle commits the write.
    always_comb begin
        busy   = (cnt_q != '0);
        commit = (cnt_q == CNT_W'(1));
    end

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> ($stable(cmd_addr) && $stable(cmd_data))); // R4

    AST_REQ_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr && req_bit) |=> busy); // R3

    AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy); // R3

endmodule

// File: rtl/codec_reg_bank.sv
// Register bank: one byte per index with reset values from the package,
// reserved indices fixed at zero, and a flag register set by hardware pulses.
// Assumes at most one host write per cycle.
module codec_reg_bank
    import codec_bridge_pkg::*;
#(
    parameter int NUM_REGS = REG_COUNT,
    parameter int ADDR_W   = IDX_W,
    parameter int DATA_W   = BYTE_W,
    parameter int FLAG_REG = FLAG_IDX,
    parameter int UP_BIT   = RAMP_UP_BIT,
    parameter int DN_BIT   = RAMP_DN_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ramp_up,
    input  logic              ramp_dn,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] flag_q
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == TEST_IDX_A || i == TEST_IDX_B) begin : g_test
            assign regs[i] = '0;
        end else if (i == FLAG_REG) begin : g_flag
            logic [DATA_W-1:0] nxt;
            // Host value first, then hardware pulses force their bits on.
            always_comb begin
                nxt = (wr_en && wr_addr == ADDR_W'(i)) ? wr_data : regs[i];
                if (ramp_up) nxt[UP_BIT] = 1'b1;
                if (ramp_dn) nxt[DN_BIT] = 1'b1;
            end
            // Flag register storage.
            always_ff @(posedge clk) begin
                if (!rst_n) regs[i] <= DATA_W'(reg_reset_value(i));
                else        regs[i] <= nxt;
            end
        end else begin : g_plain
            // Ordinary control byte written by the host.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[i] <= DATA_W'(reg_reset_value(i));
                else if (wr_en && wr_addr == ADDR_W'(i))
                    regs[i] <= wr_data;
            end
        end
    end

    // Select the addressed byte; indices past the bank read zero.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_addr == ADDR_W'(k)) rd_data = regs[k];
        end
    end

    assign flag_q = regs[FLAG_REG];

    AST_RAMP_UP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_up |=> flag_q[UP_BIT]); // R8

    AST_RAMP_DN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_dn |=> flag_q[DN_BIT]); // R8

    AST_FLAG_HOST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(FLAG_REG) && !ramp_up && !ramp_dn)
        |=> (flag_q == $past(wr_data))); // R8

endmodule

// File: rtl/codec_rd_pipe.sv
// Read settle pipeline: delays the selected byte by DEPTH register stages so
// that a new index becomes visible a fixed number of cycles later.
// Assumes DEPTH >= 1; stages clear to zero on reset.
module codec_rd_pipe #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        // One delay stage of the settle chain.
        always_ff @(posedge clk) begin
            if (!rst_n)      stage[s] <= '0;
            else if (s == 0) stage[s] <= din;
            else             stage[s] <= stage[(s == 0) ? 0 : s - 1];
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/codec_reg_bridge.sv
// Top: decodes the two host words and links the command holder, the register
// bank and the read settle pipeline. Host reads are combinational and have
// no side effects; one host write per cycle.
module codec_reg_bridge
    import codec_bridge_pkg::*;
#(
    parameter int HOST_AW     = 4,
    parameter int BUSY_CYCLES = 4,
    parameter int RD_LATENCY  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic               ramp_up_done,
    input  logic               ramp_down_done
);

    localparam logic [HOST_AW-1:0] OFS_CMD  = HOST_AW'(4'h0);
    localparam logic [HOST_AW-1:0] OFS_STAT = HOST_AW'(4'h4);
    localparam int REQ_BIT = 16;
    localparam int IRQ_BIT = 8;

    logic              cmd_wr, busy, commit;
    logic [IDX_W-1:0]  cmd_addr;
    logic [BYTE_W-1:0] cmd_data, sel_byte, settled_byte, flag_byte;
    logic              unused_wbits;

    assign cmd_wr       = host_wr && (host_addr == OFS_CMD);
    assign unused_wbits = ^{host_wdata[31:17], host_wdata[15]};

    codec_cmd_ctrl #(
        .ADDR_W(IDX_W), .DATA_W(BYTE_W), .BUSY_CYCLES(BUSY_CYCLES)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
        .req_bit(host_wdata[REQ_BIT]),
        .addr_in(host_wdata[14:8]), .data_in(host_wdata[7:0]),
        .busy(busy), .commit(commit),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    codec_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit), .wr_addr(cmd_addr), .wr_data(cmd_data),
        .ramp_up(ramp_up_done), .ramp_dn(ramp_down_done),
        .rd_addr(cmd_addr), .rd_data(sel_byte), .flag_q(flag_byte)
    );

    codec_rd_pipe #(.WIDTH(BYTE_W), .DEPTH(RD_LATENCY)) u_rdpipe (
        .clk(clk), .rst_n(rst_n), .din(sel_byte), .dout(settled_byte)
    );

    // Host read mux over the two words; other offsets read zero.
    always_comb begin
        host_rdata = '0;
        if (host_addr == OFS_CMD) begin
            host_rdata[REQ_BIT] = busy;
            host_rdata[14:8]    = cmd_addr;
            host_rdata[7:0]     = cmd_data;
        end else if (host_addr == OFS_STAT) begin
            host_rdata[IRQ_BIT] = |flag_byte;
            host_rdata[7:0]     = settled_byte;
        end
    end

endmodule

// File: tb/codec_reg_bridge_bench.sv
module codec_reg_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = 4'h0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        ramp_up_done = 1'b0;
    logic        ramp_down_done = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    codec_reg_bridge u_codec_reg_bridge (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ramp_up_done(ramp_up_done), .ramp_down_done(ramp_down_done)
    );

    logic [7:0] tbl [28] = '{8'h0c, 8'haa, 8'h78, 8'h00, 8'h00, 8'hff, 8'h03,
        8'h51, 8'h3f, 8'h00, 8'h00, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04,
        8'h0a, 8'h0a, 8'h00, 8'h00, 8'h00, 8'hc0, 8'h34, 8'h07, 8'h44, 8'h1f,
        8'h00};

    // Behavioural reference model
    logic [7:0] m_regs [28];
    logic [6:0] m_addr;
    logic [7:0] m_data;
    int         m_cnt;
    logic [7:0] m_q [$];

    function automatic logic [7:0] mlook(input int a);
        if (a < 28 && a != 20 && a != 21) return m_regs[a];
        return 8'h00;
    endfunction

    function automatic logic [31:0] mword(input logic [3:0] a);
        logic [31:0] w = '0;
        if (a == 4'h0) begin
            w[16] = (m_cnt != 0); w[14:8] = m_addr; w[7:0] = m_data;
        end else if (a == 4'h4) begin
            w[8] = (m_regs[9] != 0); w[7:0] = m_q[0];
        end
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 28; i++) m_regs[i] = tbl[i];
            m_addr = '0; m_data = '0; m_cnt = 0;
            m_q = {8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
        end else begin
            logic commit;
            m_q.push_back(mlook(int'(m_addr)));
            void'(m_q.pop_front());
            commit = (m_cnt == 1);
            if (commit && m_addr < 28 && m_addr != 20 && m_addr != 21)
                m_regs[m_addr] = m_data;
            if (ramp_up_done)   m_regs[9][3] = 1'b1;
            if (ramp_down_done) m_regs[9][2] = 1'b1;
            if (host_wr && host_addr == 4'h0 && m_cnt == 0) begin
                m_addr = host_wdata[14:8];
                m_data = host_wdata[7:0];
                m_cnt  = host_wdata[16] ? 4 : 0;
            end else if (m_cnt != 0) begin
                m_cnt = m_cnt - 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R2 word layout)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #1;
            check("R2 model compare", host_rdata, mword(host_addr));
        end
    end

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_idle();
        host_addr = 4'h0;
        #2;
        while (host_rdata[16]) begin
            @(negedge clk); #2;
        end
        @(negedge clk);
    endtask

    task automatic rd_reg(input int idx, output logic [7:0] v);
        wait_idle();
        bus_wr(4'h0, 32'(idx) << 8);
        host_addr = 4'h4;
        repeat (6) @(negedge clk);
        #2 v = host_rdata[7:0];
    endtask

    task automatic wr_reg(input int idx, input logic [7:0] d);
        wait_idle();
        bus_wr(4'h0, 32'h0001_0000 | (32'(idx) << 8) | 32'(d));
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #2 check("R1 command word after reset", host_rdata, 32'h0);

        // R6: exact settle, index 0 (0x0c) -> index 1 (0xaa)
        @(negedge clk);
        bus_wr(4'h0, 32'h0000_0100);
        host_addr = 4'h4;
        repeat (5) @(negedge clk);
        #2 check("R6 old byte after 5 cycles", {24'h0, host_rdata[7:0]}, 32'h0c);
        @(negedge clk);
        #2 check("R6 new byte after 6 cycles", {24'h0, host_rdata[7:0]}, 32'haa);

        // R10 / R7: whole reset table
        for (int i = 0; i < 28; i++) begin
            rd_reg(i, v);
            check($sformatf("R10 reset value idx %0d", i), 32'(v), 32'(tbl[i]));
        end

        // R3: busy window and commit
        wait_idle();
        bus_wr(4'h0, 32'h0001_035a);
        host_addr = 4'h0;
        #2 check("R3 busy after accept", 32'(host_rdata[16]), 32'h1);
        repeat (3) @(negedge clk);
        #2 check("R3 busy in 4th cycle", 32'(host_rdata[16]), 32'h1);
        @(negedge clk);
        #2 check("R3 busy drops after 4 cycles", 32'(host_rdata[16]), 32'h0);
        rd_reg(3, v);
        check("R3 written byte", 32'(v), 32'h5a);

        // R4: second request while busy is dropped
        wr_reg(4, 8'h11);
        bus_wr(4'h0, 32'h0001_0522);
        wait_idle();
        #2 check("R4 fields keep first command", host_rdata, 32'h0000_0411);
        rd_reg(4, v);
        check("R4 first write landed", 32'(v), 32'h11);
        rd_reg(5, v);
        check("R4 dropped write left reg 5", 32'(v), 32'hff);

        // R5: request bit clear writes nothing
        wait_idle();
        bus_wr(4'h0, 32'h0000_0699);
        host_addr = 4'h0;
        #2 check("R5 fields updated, not busy", host_rdata, 32'h0000_0699);
        rd_reg(6, v);
        check("R5 reg 6 unchanged", 32'(v), 32'h03);

        // R7: reserved and out-of-range indices
        wr_reg(20, 8'h77);
        rd_reg(20, v);
        check("R7 test index 20 reads 0", 32'(v), 32'h0);
        wr_reg(21, 8'h66);
        rd_reg(21, v);
        check("R7 test index 21 reads 0", 32'(v), 32'h0);
        wr_reg(30, 8'h55);
        rd_reg(30, v);
        check("R7 index 30 reads 0", 32'(v), 32'h0);
        rd_reg(100, v);
        check("R7 index 100 reads 0", 32'(v), 32'h0);
        rd_reg(27, v);
        check("R7 last real index intact", 32'(v), 32'h0);

        // R8 / R9: flag pulses, clear, and set-over-clear
        wait_idle();
        host_addr = 4'h4;
        ramp_up_done = 1'b1;
        @(negedge clk);
        ramp_up_done = 1'b0;
        #2 check("R9 irq immediately after pulse", 32'(host_rdata[8]), 32'h1);
        rd_reg(9, v);
        check("R8 ramp-up sets bit 3", 32'(v), 32'h08);
        wr_reg(9, 8'h00);
        wait_idle();
        host_addr = 4'h4;
        #2 check("R9 irq clear after host clear", 32'(host_rdata[8]), 32'h0);
        rd_reg(9, v);
        check("R8 host clear", 32'(v), 32'h00);
        ramp_up_done = 1'b1;
        @(negedge clk);
        ramp_up_done = 1'b0;
        wr_reg(9, 8'h00);
        repeat (3) @(negedge clk);
        ramp_down_done = 1'b1;
        @(negedge clk);
        ramp_down_done = 1'b0;
        rd_reg(9, v);
        check("R8 set wins over same-edge clear", 32'(v), 32'h04);
        host_addr = 4'h4;
        #2 check("R9 irq with bit 2 only", 32'(host_rdata[8]), 32'h1);

        // R2: writes to status offset ignored, unused offset reads 0
        wait_idle();
        bus_wr(4'h4, 32'h0001_0777);
        host_addr = 4'h0;
        #2 check("R2 status write ignored", host_rdata, 32'h0000_0900);
        host_addr = 4'h8;
        #2 check("R2 unused offset reads 0", host_rdata, 32'h0);
        @(negedge clk);

        done = 1'b1;
        finish_up();
    end

endmodule